// File: doc/BRIEF.md
# CAN Bit Timing Resynchronizer

This block builds the nominal bit time of a CAN node out of time quanta. Each bit is a one-quantum synchronization segment, then a propagation segment, then a first phase segment, then a second phase segment. The bus is sampled where the first phase segment ends and the second begins. The block advances only on ticks of a time-quantum enable that an upstream prescaler supplies. On each tick it receives the bus level already synchronized to `clk`.

Recessive-to-dominant transitions on the bus are compared with the expected synchronization quantum. An edge that arrives late stretches the part of the bit before the sample point. An edge that arrives early cuts the second phase segment. In both cases the correction is limited to a programmable jump width, and at most one such correction is made between two sample points. While the bus is idle, the surrounding frame logic can raise a hard-synchronization enable. With that enable high, the next falling edge restarts the bit at its synchronization quantum whatever the phase error.

The outputs are three one-cycle results, each registered one clock after the tick that produces it: a bit-start strobe, a sample strobe and the sampled level. The reset input is asynchronous. Its release is expected to come synchronously from the surrounding reset tree.

Top module: `can_bit_timer`

## Requirements
- R1: With no falling edge on the bus, a bit lasts 1 + prop_len + ph1_len + ph2_len quanta. `bit_stb` pulses for the first quantum of every bit. Lengths are plain binary quanta counts: prop_len, ph1_len and ph2_len take 1..8, and sjw_len takes 1..4 and must not exceed ph2_len.
- R2: `sample_stb` pulses for the last quantum of the segment that runs from the end of the synchronization quantum up to the sample point. `sample_bit` takes the bus level seen in that quantum, where 1 is recessive and 0 is dominant. The two strobes never pulse together.
- R3: State and strobes advance only on clock edges where `tq_en` is high. Every strobe appears in the clock cycle after the tick that caused it.
- R4: A falling edge seen q+1 quanta after the synchronization quantum, before the sample point, lengthens the pre-sample segment by min(q+1, sjw_len) quanta.
- R5: A falling edge in the second phase segment that lies e quanta before the next synchronization quantum, counting the edge quantum, with e <= sjw_len, makes the edge quantum the synchronization quantum of a new bit.
- R6: A falling edge in the second phase segment with e > sjw_len shortens that segment by sjw_len quanta.
- R7: A falling edge inside the synchronization quantum causes no correction, and a dominant-to-recessive transition never causes one.
- R8: After one correction, further falling edges are ignored until the next sample point.
- R9: With `hs_en` high, a falling edge makes its own quantum the synchronization quantum of a new bit regardless of phase error. No further correction happens before the next sample point.
- R10: During reset both strobes are low and `sample_bit` is 1. The first tick after reset is a synchronization quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_en | input | 1 | Time-quantum tick enable |
| rx_bit | input | 1 | Synchronized bus level, 1 recessive |
| hs_en | input | 1 | Allow hard synchronization on the next falling edge |
| prop_len | input | LEN_W | Propagation segment length in quanta |
| ph1_len | input | LEN_W | First phase segment length in quanta |
| ph2_len | input | LEN_W | Second phase segment length in quanta |
| sjw_len | input | SJW_W | Resynchronization jump width in quanta |
| sample_stb | output | 1 | Sample-point strobe |
| sample_bit | output | 1 | Bus level taken at the sample point |
| bit_stb | output | 1 | Bit-start strobe |

## Verification
The bench uses the default widths, LEN_W = 4 and SJW_W = 3. It runs these against three segment settings: a mid setting of 2/3/3 with a jump width of 2, the shortest setting of 1/1/1 with a width of 1, and the longest setting of 8/8/8 with a width of 4. The mid setting places edges on both sides of the jump width, before and after the sample point. The extreme settings cover one-quantum segments and the largest extension the counters must hold. One run toggles the quantum enable every other clock, to show that timing is counted in ticks rather than clocks.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_TSEG1 = 2'd1,
    SEG_PH2   = 2'd2
  } seg_e;

endpackage

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_en_i,
  input  logic rx_i,
  output logic fall_o
);

  logic prev_q;
  logic prev_n;

  always_comb begin
    prev_n = prev_q;
    if (tq_en_i) prev_n = rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_n;
  end

  // recessive in the previous quantum, dominant in this one
  assign fall_o = tq_en_i && prev_q && !rx_i;

endmodule

// File: rtl/can_bt_phase.sv
module can_bt_phase #(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3,
  parameter int CNT_W = LEN_W + 2
) (
  input  logic [CNT_W-1:0] q_i,
  input  logic [LEN_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic [CNT_W-1:0] ext_o,
  output logic             restart_o,
  output logic [LEN_W-1:0] short_o
);

  logic [CNT_W-1:0] sjw_w;
  logic [CNT_W-1:0] ph2_w;
  logic [CNT_W-1:0] late_err;
  logic [CNT_W-1:0] early_err;

  always_comb begin
    sjw_w     = CNT_W'(sjw_i);
    ph2_w     = CNT_W'(ph2_i);
    late_err  = q_i + CNT_W'(1);
    early_err = ph2_w - q_i;
    ext_o     = (late_err > sjw_w) ? sjw_w : late_err;
    restart_o = (early_err <= sjw_w);
    short_o   = LEN_W'(ph2_w - sjw_w);
  end

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3,
  parameter int CNT_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en_i,
  input  logic             rx_i,
  input  logic             fall_i,
  input  logic             hs_en_i,
  input  logic [LEN_W-1:0] prop_i,
  input  logic [LEN_W-1:0] ph1_i,
  input  logic [LEN_W-1:0] ph2_len_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [CNT_W-1:0] ext_i,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] short_i,
  output logic [CNT_W-1:0] q_o,
  output logic [LEN_W-1:0] ph2_o,
  output logic             bit_stb_o,
  output logic             smp_stb_o,
  output logic             smp_bit_o
);

  seg_e             seg_q, seg_n;
  logic [CNT_W-1:0] q_q, q_n, q_inc;
  logic [CNT_W-1:0] t1_q, t1_n, t1_len, t1_base;
  logic [LEN_W-1:0] ph2_q, ph2_n, ph2_cut;
  logic             done_q, done_n;
  logic             bit_hit, smp_hit;
  logic             bit_q, smp_q;
  logic             smp_bit_q, smp_bit_n;
  logic             hard_hit, corr_ok;

  assign t1_base  = CNT_W'(prop_i) + CNT_W'(ph1_i);
  assign q_inc    = q_q + CNT_W'(1);
  assign hard_hit = hs_en_i && fall_i;
  assign corr_ok  = fall_i && !done_q;

  always_comb begin
    seg_n     = seg_q;
    q_n       = q_q;
    t1_n      = t1_q;
    ph2_n     = ph2_q;
    done_n    = done_q;
    smp_bit_n = smp_bit_q;
    bit_hit   = 1'b0;
    smp_hit   = 1'b0;
    t1_len    = t1_q;
    ph2_cut   = ph2_q;
    if (tq_en_i) begin
      if (hard_hit) begin
        bit_hit = 1'b1;
        seg_n   = SEG_TSEG1;
        q_n     = '0;
        t1_n    = t1_base;
        done_n  = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            bit_hit = 1'b1;
            seg_n   = SEG_TSEG1;
            q_n     = '0;
            t1_n    = t1_base;
          end
          SEG_TSEG1: begin
            if (corr_ok) begin
              t1_len = t1_q + ext_i;
              done_n = 1'b1;
            end
            t1_n = t1_len;
            if (q_inc == t1_len) begin
              smp_hit   = 1'b1;
              smp_bit_n = rx_i;
              seg_n     = SEG_PH2;
              q_n       = '0;
              ph2_n     = ph2_len_i;
              done_n    = 1'b0;
            end else begin
              q_n = q_inc;
            end
          end
          SEG_PH2: begin
            if (corr_ok && restart_i) begin
              bit_hit = 1'b1;
              seg_n   = SEG_TSEG1;
              q_n     = '0;
              t1_n    = t1_base;
              done_n  = 1'b1;
            end else begin
              if (corr_ok) begin
                ph2_cut = short_i;
                done_n  = 1'b1;
              end
              ph2_n = ph2_cut;
              if (CNT_W'(ph2_cut) == q_inc) begin
                seg_n = SEG_SYNC;
                q_n   = '0;
              end else begin
                q_n = q_inc;
              end
            end
          end
          default: seg_n = SEG_SYNC;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= SEG_SYNC;
      q_q       <= '0;
      t1_q      <= '0;
      ph2_q     <= '0;
      done_q    <= 1'b0;
      bit_q     <= 1'b0;
      smp_q     <= 1'b0;
      smp_bit_q <= 1'b1;
    end else begin
      seg_q     <= seg_n;
      q_q       <= q_n;
      t1_q      <= t1_n;
      ph2_q     <= ph2_n;
      done_q    <= done_n;
      bit_q     <= bit_hit;
      smp_q     <= smp_hit;
      smp_bit_q <= smp_bit_n;
    end
  end

  assign q_o       = q_q;
  assign ph2_o     = ph2_q;
  assign bit_stb_o = bit_q;
  assign smp_stb_o = smp_q;
  assign smp_bit_o = smp_bit_q;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_q && smp_q)); // R2
  AST_STB_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q || smp_q) |-> $past(tq_en_i)); // R3
  AST_T1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TSEG1) |-> (q_q < t1_q)); // R1
  AST_PH2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_PH2) |-> (q_q < CNT_W'(ph2_q))); // R1
  AST_EXT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_TSEG1) |-> (t1_q <= t1_base + CNT_W'(sjw_i))); // R4
  AST_PH2_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q == SEG_PH2) |-> (CNT_W'(ph2_q) + CNT_W'(sjw_i) >= CNT_W'(ph2_len_i))); // R6
  AST_ONE_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_en_i && done_q && seg_q == SEG_TSEG1 && !hard_hit) |=> (t1_q == $past(t1_q))); // R8

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_en,
  input  logic             rx_bit,
  input  logic             hs_en,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw_len,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_stb
);

  localparam int CNT_W = LEN_W + 2;

  logic             fall;
  logic [CNT_W-1:0] q_cur;
  logic [LEN_W-1:0] ph2_cur;
  logic [CNT_W-1:0] ext;
  logic             restart;
  logic [LEN_W-1:0] ph2_short;

  can_bt_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .tq_en_i (tq_en),
    .rx_i    (rx_bit),
    .fall_o  (fall)
  );

  can_bt_phase #(.LEN_W(LEN_W), .SJW_W(SJW_W), .CNT_W(CNT_W)) u_phase (
    .q_i       (q_cur),
    .ph2_i     (ph2_cur),
    .sjw_i     (sjw_len),
    .ext_o     (ext),
    .restart_o (restart),
    .short_o   (ph2_short)
  );

  can_bt_seq #(.LEN_W(LEN_W), .SJW_W(SJW_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tq_en_i   (tq_en),
    .rx_i      (rx_bit),
    .fall_i    (fall),
    .hs_en_i   (hs_en),
    .prop_i    (prop_len),
    .ph1_i     (ph1_len),
    .ph2_len_i (ph2_len),
    .sjw_i     (sjw_len),
    .ext_i     (ext),
    .restart_i (restart),
    .short_i   (ph2_short),
    .q_o       (q_cur),
    .ph2_o     (ph2_cur),
    .bit_stb_o (bit_stb),
    .smp_stb_o (sample_stb),
    .smp_bit_o (sample_bit)
  );

  AST_CFG_SJW: assert property (@(posedge clk) disable iff (!rst_n)
    (sjw_len != '0) && (LEN_W'(sjw_len) <= ph2_len)); // R1

endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NONE = 10000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tq_en = 1'b0;
  logic       rx_bit = 1'b1;
  logic       hs_en = 1'b0;
  logic [3:0] prop_len = 4'd2;
  logic [3:0] ph1_len = 4'd3;
  logic [3:0] ph2_len = 4'd3;
  logic [2:0] sjw_len = 3'd2;
  logic       sample_stb, sample_bit, bit_stb;

  int checks = 0;
  int errors = 0;
  int tk = 0;
  logic tq_last = 1'b0;
  bit done_flag = 1'b0;

  typedef struct {
    int    kind;   // 0 bit start, 1 sample
    int    tick;
    logic  val;
    string tag;
  } ev_t;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_timer u0 (
    .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_bit(rx_bit), .hs_en(hs_en),
    .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw_len(sjw_len),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_stb(bit_stb)
  );

  always @(posedge clk) begin
    tq_last <= tq_en;
    if (!rst_n) tk <= 0;
    else if (tq_en) tk <= tk + 1;
  end

  task automatic ex(input int kind, input int tick, input logic val, input string tag);
    ev_t e;
    e.kind = kind; e.tick = tick; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic take(input int kind, input logic val);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected strobe kind=%0d tick=%0d (actual) expected none", kind, tk - 1);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.tick != tk - 1 || (kind == 1 && e.val !== val)) begin
        errors++;
        $display("FAIL %s: actual kind=%0d tick=%0d val=%b expected kind=%0d tick=%0d val=%b",
                 e.tag, kind, tk - 1, val, e.kind, e.tick, e.val);
      end
    end
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if ((bit_stb || sample_stb) && !tq_last) begin
        checks++;
        errors++;
        $display("FAIL R3: strobe without tick actual=1 expected=0");
      end
      if (bit_stb)    take(0, 1'b0);
      if (sample_stb) take(1, sample_bit);
    end
  end

  function automatic logic rxv(input int t, input int a, input int b, input int c);
    return !((t >= a && t < b) || t >= c);
  endfunction

  task automatic run_case(input int p, input int f1, input int f2, input int s,
                          input int a, input int b, input int c,
                          input bit hs, input bit gap, input int n);
    rst_n = 1'b0; tq_en = 1'b0; rx_bit = 1'b1;
    prop_len = 4'(p); ph1_len = 4'(f1); ph2_len = 4'(f2); sjw_len = 3'(s);
    hs_en = hs;
    repeat (2) @(negedge clk);
    checks++;
    if (bit_stb !== 1'b0 || sample_stb !== 1'b0 || sample_bit !== 1'b1) begin
      errors++;
      $display("FAIL R10: reset outputs actual=%b%b%b expected=001", bit_stb, sample_stb, sample_bit);
    end
    rst_n = 1'b1; tq_en = 1'b1; rx_bit = rxv(0, a, b, c);
    forever begin
      @(negedge clk);
      if (tk >= n) begin
        tq_en = 1'b0;
        break;
      end
      tq_en = gap ? ~tq_en : 1'b1;
      rx_bit = rxv(tk, a, b, c);
    end
    repeat (3) @(negedge clk);
    while (exp_q.size() != 0) begin
      ev_t e;
      e = exp_q.pop_front();
      checks++;
      errors++;
      $display("FAIL %s: missing strobe actual=none expected kind=%0d tick=%0d", e.tag, e.kind, e.tick);
    end
  endtask

  initial begin
    // R1 R2 R3 R10: nominal bits, quantum enable toggling every other clock
    ex(0, 0, 1'b0, "R10"); ex(1, 5, 1'b1, "R2"); ex(0, 9, 1'b0, "R1"); ex(1, 14, 1'b1, "R2");
    run_case(2, 3, 3, 2, NONE, NONE, NONE, 1'b0, 1'b1, 18);
    // R1 shortest segments
    ex(0, 0, 1'b0, "R1"); ex(1, 2, 1'b1, "R1"); ex(0, 4, 1'b0, "R1"); ex(1, 6, 1'b1, "R1");
    run_case(1, 1, 1, 1, NONE, NONE, NONE, 1'b0, 1'b0, 8);
    // R1 longest segments
    ex(0, 0, 1'b0, "R1"); ex(1, 16, 1'b1, "R1"); ex(0, 25, 1'b0, "R1");
    run_case(8, 8, 8, 4, NONE, NONE, NONE, 1'b0, 1'b0, 26);
    // R4 late edge within jump width
    ex(0, 0, 1'b0, "R4"); ex(1, 6, 1'b0, "R4"); ex(0, 10, 1'b0, "R4"); ex(1, 15, 1'b0, "R4");
    run_case(2, 3, 3, 2, NONE, NONE, 1, 1'b0, 1'b0, 16);
    // R4 late edge capped at jump width
    ex(0, 0, 1'b0, "R4"); ex(1, 7, 1'b0, "R4"); ex(0, 11, 1'b0, "R4");
    run_case(2, 3, 3, 2, NONE, NONE, 4, 1'b0, 1'b0, 12);
    // R4 cap at the widest jump width
    ex(0, 0, 1'b0, "R4"); ex(1, 20, 1'b0, "R4"); ex(0, 29, 1'b0, "R4");
    run_case(8, 8, 8, 4, NONE, NONE, 10, 1'b0, 1'b0, 30);
    // R5 early edge within jump width restarts the bit
    ex(0, 0, 1'b0, "R5"); ex(1, 5, 1'b1, "R5"); ex(0, 8, 1'b0, "R5"); ex(1, 13, 1'b0, "R5");
    ex(0, 17, 1'b0, "R5");
    run_case(2, 3, 3, 2, NONE, NONE, 8, 1'b0, 1'b0, 18);
    // R6 early edge beyond jump width shortens phase segment 2
    ex(0, 0, 1'b0, "R6"); ex(1, 5, 1'b1, "R6"); ex(0, 7, 1'b0, "R6"); ex(1, 12, 1'b0, "R6");
    ex(0, 16, 1'b0, "R6");
    run_case(2, 3, 3, 2, NONE, NONE, 6, 1'b0, 1'b0, 17);
    // R7 edge in the synchronization quantum
    ex(0, 0, 1'b0, "R7"); ex(1, 5, 1'b1, "R7"); ex(0, 9, 1'b0, "R7"); ex(1, 14, 1'b0, "R7");
    run_case(2, 3, 3, 2, NONE, NONE, 9, 1'b0, 1'b0, 18);
    // R7 rising edge in phase segment 2 ignored
    ex(0, 0, 1'b0, "R7"); ex(1, 5, 1'b0, "R7"); ex(0, 9, 1'b0, "R7"); ex(1, 14, 1'b1, "R7");
    run_case(2, 3, 3, 2, 0, 7, NONE, 1'b0, 1'b0, 18);
    // R8 second edge before the sample point ignored
    ex(0, 0, 1'b0, "R8"); ex(1, 6, 1'b0, "R8"); ex(0, 10, 1'b0, "R8"); ex(1, 15, 1'b0, "R8");
    run_case(2, 3, 3, 2, 1, 2, 3, 1'b0, 1'b0, 16);
    // R9 hard synchronization before the sample point
    ex(0, 0, 1'b0, "R9"); ex(0, 3, 1'b0, "R9"); ex(1, 8, 1'b0, "R9"); ex(0, 12, 1'b0, "R9");
    run_case(2, 3, 3, 2, NONE, NONE, 3, 1'b1, 1'b0, 13);
    // R9 hard synchronization with error beyond jump width
    ex(0, 0, 1'b0, "R9"); ex(1, 5, 1'b1, "R9"); ex(0, 6, 1'b0, "R9"); ex(1, 11, 1'b0, "R9");
    run_case(2, 3, 3, 2, NONE, NONE, 6, 1'b1, 1'b0, 12);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule